// File: doc/BRIEF.md
# Write-Only Two-Wire Slave with Grouped Register Access

This block is a receive-only slave on a two-wire serial bus (clock line plus open-drain data line). A fast system clock oversamples both lines. The block finds start and stop conditions and shifts in bytes on rising clock edges. It acknowledges a byte by enabling an open-drain pull-down on the data line for the ninth clock. It answers its own 7-bit device address, followed by a write direction bit. It also answers the all-zeros broadcast address.

After its own address, the first byte selects a register group. Group zero is reserved: the byte that follows it loads an internal pointer. Any nonzero group turns each following byte into a one-cycle write strobe that carries the group, the pointer and the byte. The pointer then steps by one. A host normally loads the pointer in group zero, issues a repeated start, re-addresses the device and picks the target group. It then streams data.

A broadcast followed by the reset command byte clears the pointer and re-reads the device address from a 7-bit pin input. The same pin input supplies the address after power-on reset.

Top module: `i2c_grp_wr_slave`

## Requirements
- R1: While rst_ni is low and after it rises, sda_oe_o and wr_valid_o are 0. The device address is taken from addr_pins_i and the pointer starts at 0.
- R2: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. A stop returns the block to idle, and in idle bytes clocked without a start get no acknowledge.
- R3: A first byte whose upper seven bits (bits 7..1, sent MSB first) equal the device address and whose bit 0 is 0 is acknowledged. The acknowledge is sda_oe_o = 1 while the clock line is high in the ninth clock.
- R4: A first byte with another address, or with bit 0 equal to 1, is not acknowledged. The block then acknowledges nothing and strobes nothing until the next start.
- R5: After the address, a group byte of 0x00 is acknowledged, and the next byte is acknowledged and loads the pointer without a write strobe.
- R6: After a nonzero group byte, every data byte is acknowledged and gives one wr_valid_o pulse with wr_group_o = group, wr_ptr_o = pointer and wr_data_o = byte. The pointer then increments, wrapping from 0xFF to 0x00.
- R7: A repeated start keeps the pointer, so a new group can be written at the pointer that an earlier segment left.
- R8: An all-zeros first byte is acknowledged. If the next byte is 0x06, it is acknowledged, the pointer is cleared and the device address is re-read from addr_pins_i.
- R9: After an all-zeros first byte, any second byte other than 0x06 is acknowledged and changes neither the address nor the pointer.
- R10: A start or stop that arrives partway through a byte drops that byte without a strobe.
- R11: sda_oe_o is asserted only in an acknowledge slot. It rises after the eighth clock's falling edge and drops after the ninth clock's falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for oversampling |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (resolved level) |
| addr_pins_i | input | 7 | Device address pins |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_group_o | output | 8 | Group of the write |
| wr_ptr_o | output | PTR_W | Pointer of the write |
| wr_data_o | output | 8 | Data of the write |

## Verification
The bench drives pointer loads, multi-byte bursts and repeated starts. It expects strobes in order, and a pointer that restarted at zero on every segment would give wrong wr_ptr_o values. Foreign addresses, read-direction bytes and clocking with no start must draw no acknowledge; a slave that kept listening would acknowledge them or emit strobes. The pin address is changed before a non-reset broadcast command and then before the reset command. An eager relatch would make the old address go unanswered, and a missing relatch would keep answering the old one. A pointer that misses its wrap is caught by a burst across 0xFF. A byte cut short by a stop or a start must vanish without a strobe.

// File: rtl/i2c_grp_pkg.sv
package i2c_grp_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;
  localparam logic [BYTE_W-1:0] BCAST_ADDR = 8'h00;
  localparam logic [BYTE_W-1:0] BCAST_RST  = 8'h06;
  localparam logic [BYTE_W-1:0] PTR_GROUP  = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_WAIT, ST_ACK_LO, ST_ACK_HI, ST_IGNORE
  } bus_st_e;

  typedef enum logic [2:0] {
    K_ADDR, K_GROUP, K_PTR, K_DATA, K_BCMD, K_NONE
  } byte_kind_e;
endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic scl_q, sda_q, scl_s, sda_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync_q <= '1;
          sda_sync_q <= '1;
        end else begin
          scl_sync_q <= scl_i;
          sda_sync_q <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_sync_q <= '1;
          sda_sync_q <= '1;
        end else begin
          scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
          sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_sync_q[LAST];
  assign sda_s = sda_sync_q[LAST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

  p_no_edge_on_cond_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o));
endmodule

// File: rtl/i2c_addr_latch.sv
module i2c_addr_latch
  import i2c_grp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEV_W-1:0] addr_pins_i,
  input  logic             reload_i,
  output logic [DEV_W-1:0] dev_addr_o
);
  logic reload_q;
  logic [DEV_W-1:0] dev_addr_q;

  // pins are sampled one cycle after reset release or a broadcast reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q   <= 1'b1;
      dev_addr_q <= '0;
    end else begin
      reload_q <= reload_i;
      if (reload_q) dev_addr_q <= addr_pins_i;
    end
  end

  assign dev_addr_o = dev_addr_q;

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_q && !reload_i) |=> $stable(dev_addr_o));
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_grp_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [DEV_W-1:0]  dev_addr_i,
  output logic              reload_o,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_group_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  bus_st_e     state_q;
  byte_kind_e  kind_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q, rx_byte, group_q, data_q;
  logic [PTR_W-1:0]  ptr_q, wr_ptr_q;
  logic oe_q, valid_q, reload_q;
  logic own_hit, bcast_hit;

  assign rx_byte   = {shift_q[BYTE_W-2:0], sda_s_i};
  assign own_hit   = (rx_byte[BYTE_W-1:1] == dev_addr_i) && !rx_byte[0];
  assign bcast_hit = (rx_byte == BCAST_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= K_NONE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      group_q   <= '0;
      data_q    <= '0;
      ptr_q     <= '0;
      wr_ptr_q  <= '0;
      oe_q      <= 1'b0;
      valid_q   <= 1'b0;
      reload_q  <= 1'b0;
    end else begin
      valid_q  <= 1'b0;
      reload_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_RX;
        kind_q    <= K_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: if (scl_rise_i) begin
            shift_q <= rx_byte;
            if (bit_cnt_q != LAST_BIT) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else begin
              state_q <= ST_ACK_WAIT;
              unique case (kind_q)
                K_ADDR: begin
                  if (bcast_hit)    kind_q <= K_BCMD;
                  else if (own_hit) kind_q <= K_GROUP;
                  else              state_q <= ST_IGNORE;
                end
                K_GROUP: begin
                  group_q <= rx_byte;
                  kind_q  <= (rx_byte == PTR_GROUP) ? K_PTR : K_DATA;
                end
                K_PTR: ptr_q <= PTR_W'(rx_byte);
                K_DATA: begin
                  valid_q  <= 1'b1;
                  data_q   <= rx_byte;
                  wr_ptr_q <= ptr_q;
                  ptr_q    <= ptr_q + 1'b1;
                end
                K_BCMD: begin
                  kind_q <= K_NONE;
                  if (rx_byte == BCAST_RST) begin
                    reload_q <= 1'b1;
                    ptr_q    <= '0;
                  end
                end
                default: state_q <= ST_IGNORE;
              endcase
            end
          end
          ST_ACK_WAIT: if (scl_fall_i) begin
            oe_q    <= 1'b1;
            state_q <= ST_ACK_LO;
          end
          ST_ACK_LO: if (scl_rise_i) state_q <= ST_ACK_HI;
          ST_ACK_HI: if (scl_fall_i) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= (kind_q == K_NONE) ? ST_IGNORE : ST_RX;
          end
          default: ;
        endcase
      end
    end
  end

  assign reload_o   = reload_q;
  assign sda_oe_o   = oe_q;
  assign wr_valid_o = valid_q;
  assign wr_group_o = group_q;
  assign wr_ptr_o   = wr_ptr_q;
  assign wr_data_o  = data_q;

  p_start_rx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_RX && bit_cnt_q == '0 && kind_q == K_ADDR));
  p_stop_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE && !sda_oe_o));
  p_ignore_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> (!sda_oe_o && !wr_valid_o));
  p_strobe_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (ptr_q == wr_ptr_o + 1'b1));
  p_oe_slot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (state_q == ST_ACK_LO || state_q == ST_ACK_HI));
  p_oe_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK_HI && scl_fall_i && !start_i && !stop_i) |=> !sda_oe_o);
endmodule

// File: rtl/i2c_grp_wr_slave.sv
module i2c_grp_wr_slave
  import i2c_grp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PTR_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [DEV_W-1:0]  addr_pins_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [BYTE_W-1:0] wr_group_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  logic sda_s, scl_rise, scl_fall, start_c, stop_c, reload;
  logic [DEV_W-1:0] dev_addr;

  i2c_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2c_addr_latch u_addr (
    .clk_i, .rst_ni, .addr_pins_i,
    .reload_i(reload), .dev_addr_o(dev_addr)
  );

  i2c_wr_fsm #(.PTR_W(PTR_W)) u_fsm (
    .clk_i, .rst_ni,
    .sda_s_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c), .dev_addr_i(dev_addr),
    .reload_o(reload), .sda_oe_o, .wr_valid_o,
    .wr_group_o, .wr_ptr_o, .wr_data_o
  );
endmodule

// File: tb/i2c_grp_wr_slave_bench.sv
module i2c_grp_wr_slave_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [6:0] pins = 7'h3A;
  logic sda_oe, wr_valid;
  logic [7:0] wr_group, wr_ptr, wr_data;
  wire sda_bus = sda_m & ~sda_oe;

  i2c_grp_wr_slave u_i2c_grp_wr_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_pins_i(pins), .sda_oe_o(sda_oe), .wr_valid_o(wr_valid),
    .wr_group_o(wr_group), .wr_ptr_o(wr_ptr), .wr_data_o(wr_data)
  );

  int checks = 0, errors = 0;
  logic ack_win = 1'b0;
  logic done = 1'b0;
  logic [23:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) if (rst_n && !done) begin
    chk(!(sda_oe && !ack_win), "R11", "oe outside ack slot", sda_oe, 0);
    if (wr_valid) begin
      if (exp_q.size() == 0)
        chk(0, "R6", "unexpected strobe", {wr_group, wr_ptr, wr_data}, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk({wr_group, wr_ptr, wr_data} == e, "R6", "strobe group/ptr/data",
            {wr_group, wr_ptr, wr_data}, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10); scl_m = 1'b0; tick(5);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(5); scl_m = 1'b1; tick(10); sda_m = 1'b1; tick(10);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit open_win);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(5); scl_m = 1'b1; tick(10);
      if (i == 0 && open_win) ack_win = 1'b1;
      scl_m = 1'b0; tick(5);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
    bit got;
    send_bits(b, 8, 1'b1);
    sda_m = 1'b1; tick(5); scl_m = 1'b1; tick(5);
    got = ~sda_bus; tick(5); scl_m = 1'b0; tick(8);
    ack_win = 1'b0;
    chk(got == exp_ack, req, "acknowledge", got, exp_ack);
  endtask

  task automatic expect_wr(input logic [7:0] g, input logic [7:0] p, input logic [7:0] d);
    exp_q.push_back({g, p, d});
  endtask

  initial begin
    tick(5);
    chk(sda_oe == 0 && wr_valid == 0, "R1", "outputs in reset", {sda_oe, wr_valid}, 0);
    rst_n = 1'b1;
    tick(20);
    chk(sda_oe == 0 && wr_valid == 0, "R1", "outputs after reset", {sda_oe, wr_valid}, 0);

    // R1: pointer starts at 0, pin address live after reset
    bstart(); send(8'h74, 1, "R3"); send(8'h07, 1, "R1");
    expect_wr(8'h07, 8'h00, 8'h5E); send(8'h5E, 1, "R1"); bstop();

    // R5 pointer load, R6 burst, R7 repeated start
    bstart(); send(8'h74, 1, "R3"); send(8'h00, 1, "R5"); send(8'h10, 1, "R5");
    bstart(); send(8'h74, 1, "R7"); send(8'h05, 1, "R6");
    expect_wr(8'h05, 8'h10, 8'hA1); send(8'hA1, 1, "R6");
    expect_wr(8'h05, 8'h11, 8'hB2); send(8'hB2, 1, "R6");
    expect_wr(8'h05, 8'h12, 8'hC3); send(8'hC3, 1, "R6");
    bstart(); send(8'h74, 1, "R7"); send(8'h09, 1, "R7");
    expect_wr(8'h09, 8'h13, 8'h44); send(8'h44, 1, "R7");
    bstop();

    // R4 foreign address and read direction
    bstart(); send(8'h50, 0, "R4"); send(8'h05, 0, "R4"); send(8'h99, 0, "R4"); bstop();
    bstart(); send(8'h75, 0, "R4"); send(8'h00, 0, "R4"); send(8'h20, 0, "R4"); bstop();
    bstart(); send(8'h74, 1, "R4"); send(8'h01, 1, "R4");
    expect_wr(8'h01, 8'h14, 8'h5A); send(8'h5A, 1, "R4"); bstop();

    // R9 other broadcast command does nothing
    pins = 7'h55;
    bstart(); send(8'h00, 1, "R8"); send(8'h04, 1, "R9"); bstop();
    bstart(); send(8'h74, 1, "R9"); send(8'h02, 1, "R9");
    expect_wr(8'h02, 8'h15, 8'h11); send(8'h11, 1, "R9"); bstop();

    // R8 broadcast reset relatches pins, clears pointer
    bstart(); send(8'h00, 1, "R8"); send(8'h06, 1, "R8"); bstop();
    bstart(); send(8'h74, 0, "R8"); bstop();
    bstart(); send(8'hAA, 1, "R8"); send(8'h02, 1, "R8");
    expect_wr(8'h02, 8'h00, 8'h77); send(8'h77, 1, "R8"); bstop();

    // R10 byte cut by stop, then by start
    bstart(); send(8'hAA, 1, "R10"); send(8'h03, 1, "R10");
    send_bits(8'hF0, 4, 1'b0); bstop();
    bstart(); send(8'hAA, 1, "R10"); send(8'h03, 1, "R10");
    send_bits(8'h0F, 5, 1'b0);
    bstart(); send(8'hAA, 1, "R10"); send(8'h03, 1, "R10");
    expect_wr(8'h03, 8'h01, 8'h3C); send(8'h3C, 1, "R10"); bstop();

    // R6 pointer wrap
    bstart(); send(8'hAA, 1, "R6"); send(8'h00, 1, "R6"); send(8'hFF, 1, "R6");
    bstart(); send(8'hAA, 1, "R6"); send(8'h06, 1, "R6");
    expect_wr(8'h06, 8'hFF, 8'h01); send(8'h01, 1, "R6");
    expect_wr(8'h06, 8'h00, 8'h02); send(8'h02, 1, "R6");
    bstop();

    // R2 idle after stop: no start, no acknowledge
    send(8'hAA, 0, "R2"); send(8'h06, 0, "R2"); bstop();

    tick(20);
    chk(exp_q.size() == 0, "R6", "strobes outstanding", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(0, "R2", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule